// File: doc/BRIEF.md
# Fixed-Point Round and Narrow Stage

This block is a purely combinational stage for fixed-point element arithmetic. It takes one wide intermediate element, shifts it right by a given number of bit positions, and rounds according to one of four rounding modes. The rounding increment depends on the bits that the shift discards. The rounded value is then narrowed to a smaller destination width, clamping in either signed or unsigned interpretation. A per-element flag reports whether any clamping happened.

A vector datapath instantiates one copy per element lane. The 2-bit rounding mode comes from the rounding-mode field of the vector control register. The surrounding logic merges the per-element flag into the sticky saturation bit. Both widths are parameters. The source must be at least as wide as the destination, and the destination must be wider than one bit.

Top module: `fxr_round_narrow`

## Requirements
- R1: With `shamt_i` equal to 0 no rounding increment is added in any mode, so the pre-narrowing value equals the (sign- or zero-extended) input.
- R2: Mode 2'b00 (nearest, ties up) adds 1 exactly when input bit `shamt_i-1` is set.
- R3: Mode 2'b01 (nearest, ties to even) adds 1 when bit `shamt_i-1` is set and either some bit below it is set or bit `shamt_i` is set.
- R4: Mode 2'b10 (truncate) never adds an increment.
- R5: Mode 2'b11 (jam to odd) adds 1 when bit `shamt_i` is clear and any bit below position `shamt_i` is set.
- R6: With `signed_i`=0, a rounded value greater than 2^DST_W-1 gives an all-ones result and `sat_o`=1.
- R7: With `signed_i`=1, a rounded value above 2^(DST_W-1)-1 gives the result 0 followed by all ones, and `sat_o`=1.
- R8: With `signed_i`=1, a rounded value below -2^(DST_W-1) gives the result 1 followed by all zeros, and `sat_o`=1.
- R9: When no clamping applies, `res_o` is the low DST_W bits of the rounded value and `sat_o`=0.
- R10: The shift is arithmetic when `signed_i`=1 and logical when `signed_i`=0. The saturation test uses the value after the increment, so a rounding carry can itself cause saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | SRC_W | Wide intermediate element |
| shamt_i | input | $clog2(SRC_W) | Right-shift amount, below SRC_W |
| rmode_i | input | 2 | Rounding mode: 00 ties-up, 01 ties-even, 10 truncate, 11 jam-odd |
| signed_i | input | 1 | 1 selects signed shift and clamp, 0 selects unsigned |
| res_o | output | DST_W | Rounded and narrowed element |
| sat_o | output | 1 | Clamping happened for this element |

## Verification
Rounding and saturation can act on the same element. This happens when the shifted value sits exactly at the destination limit and the increment pushes it one step past the limit. Directed inputs provoke this in both signedness modes: for example 0x1FFFF shifted by one in ties-up mode, unsigned, and the signed positive edge. The bench expects the clamped value with the flag raised. An integer-arithmetic reference model also covers the many random elements whose shift amount lands near the narrowing boundary.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

  typedef enum logic [1:0] {
    RM_NEAR_UP   = 2'b00,
    RM_NEAR_EVEN = 2'b01,
    RM_TRUNC     = 2'b10,
    RM_JAM_ODD   = 2'b11
  } rmode_e;

  // Increment decision from the three bits that summarise the discarded part.
  function automatic logic pick_incr(rmode_e mode, logic guard, logic sticky, logic lsb);
    logic inc;
    unique case (mode)
      RM_NEAR_UP:   inc = guard;
      RM_NEAR_EVEN: inc = guard & (sticky | lsb);
      RM_TRUNC:     inc = 1'b0;
      RM_JAM_ODD:   inc = ~lsb & (guard | sticky);
      default:      inc = 1'b0;
    endcase
    return inc;
  endfunction

endpackage

// File: rtl/fxr_round_incr.sv
module fxr_round_incr
  import fxr_pkg::*;
#(
  parameter int unsigned SRC_W = 32,
  parameter int unsigned SH_W  = $clog2(SRC_W)
) (
  input  logic [SRC_W-1:0] src_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic [1:0]       rmode_i,
  output logic             inc_o
);

  logic [SRC_W-1:0] below_mask;
  logic [SRC_W-1:0] at_guard;
  logic [SRC_W-1:0] at_lsb;
  logic             guard_w;
  logic             sticky_w;
  logic             lsb_w;
  logic             nz_shift;

  // Bit i lies strictly below the guard position when i < shamt-1.
  for (genvar i = 0; i < SRC_W; i++) begin : g_mask
    assign below_mask[i] = ({1'b0, shamt_i} > (SH_W+1)'(i + 1));
  end

  assign nz_shift = (shamt_i != '0);
  assign at_guard = src_i >> (shamt_i - 1'b1);
  assign at_lsb   = src_i >> shamt_i;
  assign guard_w  = nz_shift & at_guard[0];
  assign sticky_w = nz_shift & (|(src_i & below_mask));
  assign lsb_w    = at_lsb[0];

  always_comb begin
    if (!nz_shift) inc_o = 1'b0;
    else           inc_o = pick_incr(rmode_e'(rmode_i), guard_w, sticky_w, lsb_w);
  end

endmodule

// File: rtl/fxr_shift_add.sv
module fxr_shift_add #(
  parameter int unsigned SRC_W = 32,
  parameter int unsigned SH_W  = $clog2(SRC_W)
) (
  input  logic [SRC_W-1:0] src_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic             signed_i,
  input  logic             inc_i,
  output logic [SRC_W:0]   rounded_o
);

  logic [SRC_W:0] ext_w;
  logic [SRC_W:0] shifted_w;

  // One extra bit: sign copy for signed data, zero for unsigned data.
  assign ext_w     = {signed_i & src_i[SRC_W-1], src_i};
  assign shifted_w = $unsigned($signed(ext_w) >>> shamt_i);
  assign rounded_o = shifted_w + {{SRC_W{1'b0}}, inc_i};

endmodule

// File: rtl/fxr_narrow_sat.sv
module fxr_narrow_sat #(
  parameter int unsigned SRC_W = 32,
  parameter int unsigned DST_W = 16
) (
  input  logic [SRC_W:0]   rounded_i,
  input  logic             signed_i,
  output logic [DST_W-1:0] res_o,
  output logic             over_o,
  output logic             under_o
);

  localparam int unsigned HI_N = SRC_W - DST_W + 2;
  localparam logic [DST_W-1:0] S_MAX = {1'b0, {(DST_W-1){1'b1}}};
  localparam logic [DST_W-1:0] S_MIN = {1'b1, {(DST_W-1){1'b0}}};

  logic [HI_N-1:0]  s_top;
  logic [HI_N-2:0]  u_top;
  logic             sign_w;

  assign s_top  = rounded_i[SRC_W:DST_W-1];
  assign u_top  = rounded_i[SRC_W:DST_W];
  assign sign_w = rounded_i[SRC_W];

  always_comb begin
    over_o  = 1'b0;
    under_o = 1'b0;
    res_o   = rounded_i[DST_W-1:0];
    if (signed_i) begin
      if (!sign_w && (|s_top)) begin
        over_o = 1'b1;
        res_o  = S_MAX;
      end else if (sign_w && !(&s_top)) begin
        under_o = 1'b1;
        res_o   = S_MIN;
      end
    end else if (|u_top) begin
      over_o = 1'b1;
      res_o  = '1;
    end
  end

  always_comb begin
    p_one_side_r7: assert (!(over_o && under_o))
      else $error("clamp raised both directions");
  end

endmodule

// File: rtl/fxr_round_narrow.sv
module fxr_round_narrow
  import fxr_pkg::*;
#(
  parameter int unsigned SRC_W = 32,
  parameter int unsigned DST_W = 16,
  parameter int unsigned SH_W  = $clog2(SRC_W)
) (
  input  logic [SRC_W-1:0] src_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic [1:0]       rmode_i,
  input  logic             signed_i,
  output logic [DST_W-1:0] res_o,
  output logic             sat_o
);

  localparam logic [DST_W-1:0] S_MAX = {1'b0, {(DST_W-1){1'b1}}};
  localparam logic [DST_W-1:0] S_MIN = {1'b1, {(DST_W-1){1'b0}}};

  logic             inc_w;
  logic [SRC_W:0]   rounded_w;
  logic             over_w;
  logic             under_w;

  fxr_round_incr #(.SRC_W(SRC_W), .SH_W(SH_W)) u_incr (
    .src_i   (src_i),
    .shamt_i (shamt_i),
    .rmode_i (rmode_i),
    .inc_o   (inc_w)
  );

  fxr_shift_add #(.SRC_W(SRC_W), .SH_W(SH_W)) u_shift (
    .src_i     (src_i),
    .shamt_i   (shamt_i),
    .signed_i  (signed_i),
    .inc_i     (inc_w),
    .rounded_o (rounded_w)
  );

  fxr_narrow_sat #(.SRC_W(SRC_W), .DST_W(DST_W)) u_sat (
    .rounded_i (rounded_w),
    .signed_i  (signed_i),
    .res_o     (res_o),
    .over_o    (over_w),
    .under_o   (under_w)
  );

  assign sat_o = over_w | under_w;

  always_comb begin
    if (shamt_i == '0) begin
      p_zero_shift_r1: assert (rounded_w == {signed_i & src_i[SRC_W-1], src_i})
        else $error("zero shift altered the value");
    end
    if (rmode_i == RM_TRUNC) begin
      p_trunc_noinc_r4: assert (!inc_w) else $error("truncate mode incremented");
    end
    if (!signed_i && sat_o) begin
      p_usat_ones_r6: assert (&res_o) else $error("unsigned clamp not all ones");
    end
    if (signed_i && over_w) begin
      p_smax_r7: assert (res_o == S_MAX) else $error("signed high clamp wrong");
    end
    if (signed_i && under_w) begin
      p_smin_r8: assert (res_o == S_MIN) else $error("signed low clamp wrong");
    end
    if (!sat_o) begin
      p_pass_low_r9: assert (res_o == rounded_w[DST_W-1:0])
        else $error("unclamped result not low bits");
    end
  end

endmodule

// File: tb/sim_fxr_round_narrow.sv
`timescale 1ns/1ps
module sim_fxr_round_narrow;

  localparam int SRC_W = 32;
  localparam int DST_W = 16;
  localparam int SH_W  = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [SRC_W-1:0] src;
  logic [SH_W-1:0]  shamt;
  logic [1:0]       rmode;
  logic             sgn;
  logic [DST_W-1:0] res;
  logic             sat;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fxr_round_narrow #(.SRC_W(SRC_W), .DST_W(DST_W)) u0 (
    .src_i(src), .shamt_i(shamt), .rmode_i(rmode), .signed_i(sgn),
    .res_o(res), .sat_o(sat)
  );

  // Integer reference: floor quotient, remainder, then mode rule and clamp.
  function automatic longint ref_round(logic [SRC_W-1:0] s, int sh, int m, bit sg);
    longint v, q, rem, half;
    bit inc;
    v = sg ? longint'($signed(s)) : longint'({32'b0, s});
    q = v >>> sh;
    rem = v - (q <<< sh);
    half = (sh == 0) ? 0 : (longint'(1) <<< (sh - 1));
    inc = 0;
    if (sh != 0) begin
      case (m)
        0: inc = (rem >= half);
        1: inc = (rem > half) || (rem == half && q[0]);
        2: inc = 0;
        default: inc = (rem != 0) && !q[0];
      endcase
    end
    return q + longint'(inc);
  endfunction

  function automatic void ref_out(longint r, bit sg, output logic [DST_W-1:0] er, output bit es);
    longint smax = (longint'(1) <<< (DST_W - 1)) - 1;
    longint smin = -(longint'(1) <<< (DST_W - 1));
    longint umax = (longint'(1) <<< DST_W) - 1;
    es = 0;
    if (sg) begin
      if (r > smax) begin er = smax[DST_W-1:0]; es = 1; end
      else if (r < smin) begin er = smin[DST_W-1:0]; es = 1; end
      else er = r[DST_W-1:0];
    end else begin
      if (r > umax) begin er = '1; es = 1; end
      else er = r[DST_W-1:0];
    end
  endfunction

  task automatic run(string tag, logic [SRC_W-1:0] s, int sh, int m, bit sg);
    logic [DST_W-1:0] er;
    bit es;
    longint r;
    @(negedge clk);
    src = s; shamt = sh[SH_W-1:0]; rmode = m[1:0]; sgn = sg;
    #1;
    r = ref_round(s, sh, m, sg);
    ref_out(r, sg, er, es);
    n_cmp++;
    if (res !== er || sat !== es) begin
      n_bad++;
      $display("FAIL %s src=%h sh=%0d mode=%0d sgn=%0d actual res=%h sat=%0b expected res=%h sat=%0b",
               tag, s, sh, m, sg, res, sat, er, es);
    end
  endtask

  function automatic string rand_tag(logic [SRC_W-1:0] s, int sh, int m, bit sg);
    logic [DST_W-1:0] er;
    bit es;
    longint r;
    r = ref_round(s, sh, m, sg);
    ref_out(r, sg, er, es);
    if (es) return sg ? ((r > 0) ? "R7" : "R8") : "R6";
    if (sh == 0) return "R1";
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    src = '0; shamt = '0; rmode = '0; sgn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (res !== '0 || sat !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 reset idle actual res=%h sat=%0b expected res=0000 sat=0", res, sat);
    end
    rst_n = 1'b1;

    // R1: no shift, no increment whatever the mode
    for (int m = 0; m < 4; m++) run("R1", 32'h0000_1234, 0, m, 0);
    // R2..R5: 10 >> 2 is a tie with even quotient; 14 >> 2 a tie with odd quotient
    run("R2", 32'd10, 2, 0, 0);
    run("R3", 32'd10, 2, 1, 0);
    run("R3", 32'd14, 2, 1, 0);
    run("R3", 32'd11, 2, 1, 0);
    run("R4", 32'd15, 2, 2, 0);
    run("R5", 32'd10, 2, 3, 0);
    run("R5", 32'd14, 2, 3, 0);
    run("R5", 32'd12, 2, 3, 0);
    // negative operand, arithmetic shift (R10)
    run("R10", 32'hFFFF_FFFD, 1, 0, 1);
    run("R10", 32'hFFFF_FFFD, 1, 1, 1);
    run("R10", 32'hFFFF_FFFD, 1, 3, 1);
    run("R10", 32'h8000_0000, 4, 2, 0);
    // unsigned edge and rounding carry into saturation
    run("R9", 32'h0000_FFFF, 0, 0, 0);
    run("R6", 32'h0001_0000, 0, 0, 0);
    run("R10", 32'h0001_FFFF, 1, 0, 0);
    run("R6", 32'hFFFF_FFFF, 31, 0, 0);
    // signed edges
    run("R9", 32'h0000_7FFF, 0, 0, 1);
    run("R7", 32'h0000_8000, 0, 0, 1);
    run("R10", 32'h0000_FFFF, 1, 0, 1);
    run("R9", 32'hFFFF_8000, 0, 0, 1);
    run("R8", 32'hFFFF_7FFF, 0, 0, 1);
    run("R8", 32'h8000_0000, 0, 3, 1);

    void'($urandom(32'd2024));
    for (int k = 0; k < 3000; k++) begin
      logic [SRC_W-1:0] s;
      int sh, m, kind;
      bit sg;
      kind = $urandom % 3;
      s = $urandom;
      if (kind == 1) s = {{16{s[16]}}, s[15:0]};
      sh = (kind == 2) ? (14 + $urandom % 4) : ($urandom % 32);
      m  = $urandom % 4;
      sg = $urandom % 2;
      run(rand_tag(s, sh, m, sg), s, sh, m, sg);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule